// File: doc/BRIEF.md
# Power-Up Restore Sequencer

This controller brings a volatile working array back to a known state after the supply has dropped out. A nonvolatile shadow copy holds the saved image. Two clean, synchronous flags describe the supply. The first says it has fallen below the reset level. The second says it has climbed past a higher switch level. Any low-supply indication sets a pending restore request, including the state right after reset. The request is serviced only once the supply is back above the switch level.

During a restore the block walks the shadow copy from address zero upward, one word per clock. Each word goes straight into the working array through the array's single port. For the whole restore window, host reads and writes are held off the array. The window is a fixed number of clock cycles. It is never shorter than the copy itself. The block then raises a one-cycle completion pulse. If the host was still driving a write strobe on the last busy cycle, an error pulse is raised alongside it, because that write collides with the end of the restore.

A new low-supply indication during a restore cancels it at once. The request stays pending, and the restore begins again from address zero when the supply recovers.

Top module: `nvr_restore_ctrl`

## Requirements
- R1: After reset the block holds a pending request without any low-supply flag having been seen: `busy_o`, `done_o` and `wr_err_o` are 0, and a restore starts as soon as `vgood_i` is 1.
- R2: A `vlow_i` pulse of one cycle sets a pending request after a completed restore. While `vlow_i` is 1 no restore starts. The restore begins on the cycle after `vlow_i` returns to 0 with `vgood_i` at 1.
- R3: A pending request never starts a restore while `vgood_i` is 0.
- R4: With a request pending, `vgood_i` at 1 and `vlow_i` at 0 on a clock edge, `busy_o` is 1 in the following cycle.
- R5: In busy cycle n (counted from 0), for n below DEPTH, the block presents a copy write. In that write `mem_we_o` is 1, `shadow_addr_o` and `mem_addr_o` equal n, and `mem_wdata_o` equals `shadow_rdata_i`. The addresses therefore ascend from 0 to DEPTH-1.
- R6: `busy_o` stays 1 for exactly max(RESTORE_CYCLES, DEPTH) consecutive cycles. No array write occurs in busy cycles at or beyond DEPTH.
- R7: While `busy_o` is 1, host requests have no effect on the array port. `mem_re_o` is 0, and `mem_we_o`, `mem_addr_o` and `mem_wdata_o` carry only copy traffic.
- R8: While `busy_o` is 0, the host inputs pass straight to the array port: `host_addr_i`, `host_wdata_i`, `host_we_i` and `host_re_i` appear on `mem_addr_o`, `mem_wdata_o`, `mem_we_o` and `mem_re_o`.
- R9: `done_o` pulses for one cycle, in the cycle right after the last busy cycle. The request is then cleared, so no further restore starts until `vlow_i` is seen again.
- R10: `wr_err_o` is 1 together with `done_o` exactly when `host_we_i` was 1 during the last busy cycle. Otherwise it is 0.
- R11: `vlow_i` at 1 during a busy cycle ends the restore on that edge, with no `done_o`. The request stays pending, and the next restore starts again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| vlow_i | input | 1 | Supply is below the reset level |
| vgood_i | input | 1 | Supply is above the switch level |
| host_addr_i | input | ADDR_W | Host access address |
| host_wdata_i | input | DATA_W | Host write data |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| shadow_addr_o | output | ADDR_W | Shadow copy read address |
| shadow_rdata_i | input | DATA_W | Shadow copy read data, same cycle |
| mem_addr_o | output | ADDR_W | Working array address |
| mem_wdata_o | output | DATA_W | Working array write data |
| mem_we_o | output | 1 | Working array write enable |
| mem_re_o | output | 1 | Working array read enable |
| busy_o | output | 1 | Restore in progress |
| done_o | output | 1 | One-cycle restore completion pulse |
| wr_err_o | output | 1 | Host write collided with restore completion |

## Verification
The hardest case to reach is a restore cancelled partway through. A low-supply flag has to land while the copy is still under way, and the following restore must be seen to begin again at address zero rather than resume. The stimulus runs a restore cycle by cycle. Partway through the copy it raises `vlow_i` and drops `vgood_i`, then confirms that the busy window closes with no completion pulse. It then restores the supply and follows the second restore from its first write to the final completion. The write-collision error is reached by holding the host write strobe exactly on the last busy cycle, since that cycle is known from the restore length.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } nvr_state_e;

    function automatic int run_len(input int depth, input int restore);
        return (restore > depth) ? restore : depth;
    endfunction

endpackage

// File: rtl/nvr_req_latch.sv
module nvr_req_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic vlow_i,
    input  logic clear_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = vlow_i | (pend_q & ~clear_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pend_q <= 1'b1;
        else       pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/nvr_seq.sv
module nvr_seq
    import nvr_pkg::*;
#(
    parameter int DEPTH          = 8192,
    parameter int RESTORE_CYCLES = 10000,
    parameter int ADDR_W         = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vlow_i,
    input  logic              vgood_i,
    input  logic              pend_i,
    input  logic              host_we_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              finish_o,
    output logic              copy_we_o,
    output logic [ADDR_W-1:0] copy_addr_o
);
    localparam int RUN_LEN = run_len(DEPTH, RESTORE_CYCLES);
    localparam int CNT_W   = $clog2(RUN_LEN + 1);

    typedef struct packed {
        nvr_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      last_w;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        last_w   = (r_q.cnt == CNT_W'(RUN_LEN - 1));
        finish_o = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (pend_i && vgood_i && !vlow_i) begin
                    r_d.state = ST_RUN;
                    r_d.cnt   = '0;
                end
            end
            ST_RUN: begin
                if (vlow_i) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                end else if (last_w) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                    r_d.done  = 1'b1;
                    r_d.err   = host_we_i;
                    finish_o  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.state == ST_RUN);
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign copy_we_o   = busy_o && (r_q.cnt < CNT_W'(DEPTH));
    assign copy_addr_o = r_q.cnt[ADDR_W-1:0];
endmodule

// File: rtl/nvr_port_mux.sv
module nvr_port_mux #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              busy_i,
    input  logic              copy_we_i,
    input  logic [ADDR_W-1:0] copy_addr_i,
    input  logic [DATA_W-1:0] shadow_rdata_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic              host_we_i,
    input  logic              host_re_i,
    output logic [ADDR_W-1:0] shadow_addr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o
);
    always_comb begin
        shadow_addr_o = copy_addr_i;
        if (busy_i) begin
            mem_addr_o  = copy_addr_i;
            mem_wdata_o = shadow_rdata_i;
            mem_we_o    = copy_we_i;
            mem_re_o    = 1'b0;
        end else begin
            mem_addr_o  = host_addr_i;
            mem_wdata_o = host_wdata_i;
            mem_we_o    = host_we_i;
            mem_re_o    = host_re_i;
        end
    end
endmodule

// File: rtl/nvr_restore_ctrl.sv
module nvr_restore_ctrl #(
    parameter int DEPTH          = 8192,
    parameter int DATA_W         = 8,
    parameter int RESTORE_CYCLES = 10000,
    parameter int ADDR_W         = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vlow_i,
    input  logic              vgood_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic              host_we_i,
    input  logic              host_re_i,
    output logic [ADDR_W-1:0] shadow_addr_o,
    input  logic [DATA_W-1:0] shadow_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              wr_err_o
);
    logic              pend_w;
    logic              finish_w;
    logic              copy_we_w;
    logic [ADDR_W-1:0] copy_addr_w;

    nvr_req_latch u_req (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .vlow_i  (vlow_i),
        .clear_i (finish_w),
        .pend_o  (pend_w)
    );

    nvr_seq #(
        .DEPTH          (DEPTH),
        .RESTORE_CYCLES (RESTORE_CYCLES),
        .ADDR_W         (ADDR_W)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .vlow_i      (vlow_i),
        .vgood_i     (vgood_i),
        .pend_i      (pend_w),
        .host_we_i   (host_we_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (wr_err_o),
        .finish_o    (finish_w),
        .copy_we_o   (copy_we_w),
        .copy_addr_o (copy_addr_w)
    );

    nvr_port_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .busy_i         (busy_o),
        .copy_we_i      (copy_we_w),
        .copy_addr_i    (copy_addr_w),
        .shadow_rdata_i (shadow_rdata_i),
        .host_addr_i    (host_addr_i),
        .host_wdata_i   (host_wdata_i),
        .host_we_i      (host_we_i),
        .host_re_i      (host_re_i),
        .shadow_addr_o  (shadow_addr_o),
        .mem_addr_o     (mem_addr_o),
        .mem_wdata_o    (mem_wdata_o),
        .mem_we_o       (mem_we_o),
        .mem_re_o       (mem_re_o)
    );
endmodule

// File: rtl/nvr_restore_chk.sv
module nvr_restore_chk #(
    parameter int DEPTH          = 8192,
    parameter int DATA_W         = 8,
    parameter int RESTORE_CYCLES = 10000,
    parameter int ADDR_W         = $clog2(DEPTH)
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              vlow_i,
    input logic [ADDR_W-1:0] shadow_addr_o,
    input logic [DATA_W-1:0] shadow_rdata_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              wr_err_o
);
    localparam int RUN_LEN = nvr_pkg::run_len(DEPTH, RESTORE_CYCLES);
    localparam int LEN_W   = $clog2(RUN_LEN + 2);

    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !busy_o) len_q <= '0;
        else                  len_q <= len_q + LEN_W'(1);
    end

    a_r7_no_host_read: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> !mem_re_o);

    a_r5_starts_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> (mem_we_o && mem_addr_o == '0));

    a_r5_ascending: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && mem_we_o && $past(busy_o) && $past(mem_we_o))
            |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + ADDR_W'(1)));

    a_r5_copy_data: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && mem_we_o) |-> (mem_wdata_o == shadow_rdata_i && shadow_addr_o == mem_addr_o));

    a_r6_window_len: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> len_q == LEN_W'(RUN_LEN));

    a_r9_done_follows_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_err_o |-> done_o);

    a_r11_abort: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && vlow_i) |=> (!busy_o && !done_o));
endmodule

bind nvr_restore_ctrl nvr_restore_chk #(
    .DEPTH          (DEPTH),
    .DATA_W         (DATA_W),
    .RESTORE_CYCLES (RESTORE_CYCLES),
    .ADDR_W         (ADDR_W)
) chk_i (.*);

// File: tb/nvr_restore_ctrl_tb_top.sv
module nvr_restore_ctrl_tb_top;
    localparam int DEPTH   = 16;
    localparam int DATA_W  = 8;
    localparam int RESTORE = 24;
    localparam int AW      = $clog2(DEPTH);
    localparam int RUN_LEN = (RESTORE > DEPTH) ? RESTORE : DEPTH;

    logic              clk = 1'b0;
    logic              rst;
    logic              vlow, vgood;
    logic [AW-1:0]     host_addr;
    logic [DATA_W-1:0] host_wdata;
    logic              host_we, host_re;
    logic [AW-1:0]     shadow_addr, mem_addr;
    logic [DATA_W-1:0] shadow_rdata, mem_wdata;
    logic              mem_we, mem_re, busy, done, wr_err;
    logic [DATA_W-1:0] arr [DEPTH];

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [DATA_W-1:0] shf(input int a);
        return DATA_W'((a * 59) ^ 165);
    endfunction

    assign shadow_rdata = shf(int'(shadow_addr));

    always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;

    nvr_restore_ctrl #(
        .DEPTH (DEPTH), .DATA_W (DATA_W), .RESTORE_CYCLES (RESTORE)
    ) dut_i (
        .clk_i (clk), .rst_i (rst), .vlow_i (vlow), .vgood_i (vgood),
        .host_addr_i (host_addr), .host_wdata_i (host_wdata),
        .host_we_i (host_we), .host_re_i (host_re),
        .shadow_addr_o (shadow_addr), .shadow_rdata_i (shadow_rdata),
        .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata),
        .mem_we_o (mem_we), .mem_re_o (mem_re),
        .busy_o (busy), .done_o (done), .wr_err_o (wr_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; vlow = 1'b0; vgood = 1'b0;
        host_addr = '0; host_wdata = '0; host_we = 1'b0; host_re = 1'b0;
        for (int i = 0; i < DEPTH; i++) arr[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(busy == 0 && done == 0 && wr_err == 0, "R1 reset outputs", int'(busy), 0);
        repeat (4) @(negedge clk);
        #1 chk(busy == 0, "R3 no start without vgood", int'(busy), 0);
        host_addr = AW'(5); host_re = 1'b1; #1;
        chk(mem_re == 1 && mem_addr == AW'(5) && mem_we == 0, "R8 read passthrough", int'(mem_addr), 5);
        host_re = 1'b0; host_we = 1'b1; host_wdata = 8'h5C; host_addr = AW'(9); #1;
        chk(mem_we == 1 && mem_wdata == 8'h5C && mem_addr == AW'(9) && mem_re == 0,
            "R8 write passthrough", int'(mem_wdata), 'h5C);
        host_we = 1'b0;
    endtask

    task automatic begin_recall(input string tag);
        @(negedge clk);
        vlow = 1'b0; vgood = 1'b1;
        @(negedge clk); #1;
        chk(busy == 1, tag, int'(busy), 1);
    endtask

    task automatic run_body(input bit wr_last, input int abort_at);
        for (int c = 0; c < RUN_LEN; c++) begin
            if (c > 0) @(negedge clk);
            host_addr  = AW'(c ^ 3);
            host_wdata = 8'hEE;
            host_re    = 1'b1;
            host_we    = (c == RUN_LEN - 1) ? wr_last : 1'b1;
            if (c == abort_at) begin vlow = 1'b1; vgood = 1'b0; end
            #1;
            chk(busy == 1, "R6 busy held", int'(busy), 1);
            chk(mem_re == 0, "R7 host read blocked", int'(mem_re), 0);
            if (c < DEPTH) begin
                chk(mem_we == 1 && mem_addr == AW'(c) && shadow_addr == AW'(c)
                    && mem_wdata == shf(c), "R5 copy word", int'(mem_addr), c);
            end else begin
                chk(mem_we == 0, "R6 no write past depth", int'(mem_we), 0);
            end
            if (c == abort_at) begin
                @(negedge clk); #1;
                host_we = 1'b0; host_re = 1'b0;
                chk(busy == 0 && done == 0, "R11 abort ends restore", int'(busy), 0);
                return;
            end
        end
        @(negedge clk); #1;
        chk(busy == 0 && done == 1, "R9 done after window", int'(done), 1);
        chk(wr_err == wr_last, "R10 write collision flag", int'(wr_err), int'(wr_last));
        host_we = 1'b0; host_re = 1'b0;
        @(negedge clk); #1;
        chk(done == 0 && wr_err == 0, "R9 done single cycle", int'(done), 0);
        begin
            int bad = 0;
            for (int i = 0; i < DEPTH; i++) if (arr[i] !== shf(i)) bad++;
            chk(bad == 0, "R5 array restored", bad, 0);
        end
    endtask

    task automatic t_first();
        begin_recall("R1 R4 reset request starts restore");
        run_body(1'b0, -1);
    endtask

    task automatic t_no_retrigger();
        repeat (5) @(negedge clk);
        #1 chk(busy == 0, "R9 request cleared", int'(busy), 0);
    endtask

    task automatic t_brownout();
        for (int i = 0; i < DEPTH; i++) arr[i] = '0;
        @(negedge clk);
        vlow = 1'b1;
        @(negedge clk); #1;
        chk(busy == 0, "R2 no start while vlow", int'(busy), 0);
        vlow = 1'b0;
        @(negedge clk); #1;
        chk(busy == 1, "R2 brownout relatches request", int'(busy), 1);
        run_body(1'b1, -1);
    endtask

    task automatic t_abort();
        @(negedge clk);
        vgood = 1'b0; vlow = 1'b1;
        @(negedge clk);
        vlow = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk(busy == 0, "R3 waits for vgood", int'(busy), 0);
        for (int i = 0; i < DEPTH; i++) arr[i] = '0;
        begin_recall("R4 start on vgood");
        run_body(1'b0, 7);
        begin_recall("R11 request kept after abort");
        run_body(1'b0, -1);
    endtask

    initial begin
        #(200000 * 8);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_first();
        t_no_retrigger();
        t_brownout();
        t_abort();
        t_no_retrigger();
        finish_run();
    end
endmodule